// File: doc/BRIEF.md
# Acquisition Real-Time and Live-Time Countdown Timers

This block holds the two acquisition timers of a pulse-processing front end. The real-time timer measures elapsed acquisition time. The live-time timer measures only the time during which the processor is free to accept events. The host presets each timer through a 16-bit register port. While acquisition is enabled, each timer counts down on a tick strobe. The block drives a run permit that lets a downstream pulse-processing state machine work only while both remaining counts are nonzero.

A snapshot request copies both running 32-bit counts into a second register set in the same clock. Software can then read a coherent pair of live and real values while the running timers continue to count. Reads are combinational from the read address. Writes land on the clock edge after they are presented.

Top module: `acq_timer_top`

## Requirements
- R1: A synchronous reset clears both running counts and both snapshot copies to zero, so the run permit reads low after reset.
- R2: Register addresses are: 0 live low half, 1 live high half, 2 real low half, 3 real high half (running, writable). A write to one half changes only that half of that timer, and the new value is readable on the next cycle.
- R3: While acquisition is enabled and the real count is nonzero, each tick lowers the real count by exactly one.
- R4: The live count is lowered by one on an enabled tick only when the busy input is low. A tick with busy high leaves it unchanged.
- R5: With acquisition enable low, ticks change neither count.
- R6: A write to a timer in the same cycle as a tick takes priority. That timer takes the written half merged with its other half, and no decrement is applied to it.
- R7: A count that reaches zero stays at zero on further ticks and never wraps.
- R8: The run permit is high exactly when both the live and the real count are nonzero.
- R9: Addresses 4 to 7 return the snapshot of live low, live high, real low and real high. A snapshot request captures both full counts in one clock. Snapshots are otherwise unchanged, and writes to addresses 4 to 7 have no effect.
- R10: Full 32-bit arithmetic applies. A preset of all ones counts down to 0xFFFFFFFE, and a borrow passes from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one count per high cycle |
| busy | input | 1 | Dead-time indicator; blocks live-time counting |
| acq_enable | input | 1 | Acquisition enable; low freezes both timers |
| snap_req | input | 1 | Copy both running counts into the snapshot registers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| run_permit | output | 1 | High while both counts are nonzero |

## Verification
The bench builds the block with its default 16-bit half width, so each timer is a full 32-bit counter. Small presets bring the zero crossing, saturation and the permit fall within a few ticks. Presets next to a 16-bit boundary bring the borrow from the low half into the high half, and the all-ones start, within a single tick. No long run is needed for either.

// File: rtl/acq_timer_pkg.sv
package acq_timer_pkg;

    localparam int NUM_TIMERS = 2;
    localparam int TMR_LIVE   = 0;
    localparam int TMR_REAL   = 1;

    typedef enum logic [2:0] {
        RA_LIVE_LO = 3'd0,
        RA_LIVE_HI = 3'd1,
        RA_REAL_LO = 3'd2,
        RA_REAL_HI = 3'd3,
        RA_SNAP_LIVE_LO = 3'd4,
        RA_SNAP_LIVE_HI = 3'd5,
        RA_SNAP_REAL_LO = 3'd6,
        RA_SNAP_REAL_HI = 3'd7
    } reg_addr_e;

    // Running registers sit in the lower half of the map
    function automatic logic is_running(input logic [2:0] a);
        return a[2] == 1'b0;
    endfunction

    // Timer index: bit 1 selects live (0) or real (1)
    function automatic int timer_of(input logic [2:0] a);
        return a[1] ? TMR_REAL : TMR_LIVE;
    endfunction

    // Half select: bit 0 selects low (0) or high (1)
    function automatic logic is_high_half(input logic [2:0] a);
        return a[0];
    endfunction

endpackage

// File: rtl/acq_countdown.sv
module acq_countdown #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wr_data,
    output logic [2*HALF_W-1:0]   cnt
);
    localparam int CNT_W = 2 * HALF_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[HALF_W-1:0]     <= wr_data;
            if (wr_hi) cnt[CNT_W-1:HALF_W] <= wr_data;
        end else if (step && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/acq_snapshot.sv
module acq_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [CNT_W-1:0] live_in,
    input  logic [CNT_W-1:0] real_in,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] real_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            real_q <= '0;
        end else if (capture) begin
            live_q <= live_in;
            real_q <= real_in;
        end
    end
endmodule

// File: rtl/acq_timer_top.sv
module acq_timer_top
    import acq_timer_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              busy,
    input  logic              acq_enable,
    input  logic              snap_req,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              run_permit
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_arr [NUM_TIMERS];
    logic [CNT_W-1:0] live_cnt, real_cnt, live_snap, real_snap;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
        logic step, hit;
        if (g == TMR_LIVE) begin : g_live
            assign step = tick && acq_enable && !busy;
        end else begin : g_real
            assign step = tick && acq_enable;
        end
        assign hit = wr_en && is_running(wr_addr) && (timer_of(wr_addr) == g);

        acq_countdown #(.HALF_W(HALF_W)) cnt_i (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .wr_lo   (hit && !is_high_half(wr_addr)),
            .wr_hi   (hit &&  is_high_half(wr_addr)),
            .wr_data (wr_data),
            .cnt     (cnt_arr[g])
        );
    end

    assign live_cnt = cnt_arr[TMR_LIVE];
    assign real_cnt = cnt_arr[TMR_REAL];

    acq_snapshot #(.CNT_W(CNT_W)) snap_i (
        .clk     (clk),
        .rst     (rst),
        .capture (snap_req),
        .live_in (live_cnt),
        .real_in (real_cnt),
        .live_q  (live_snap),
        .real_q  (real_snap)
    );

    assign run_permit = (live_cnt != '0) && (real_cnt != '0);

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_LIVE_LO:      rd_data = live_cnt[HALF_W-1:0];
            RA_LIVE_HI:      rd_data = live_cnt[CNT_W-1:HALF_W];
            RA_REAL_LO:      rd_data = real_cnt[HALF_W-1:0];
            RA_REAL_HI:      rd_data = real_cnt[CNT_W-1:HALF_W];
            RA_SNAP_LIVE_LO: rd_data = live_snap[HALF_W-1:0];
            RA_SNAP_LIVE_HI: rd_data = live_snap[CNT_W-1:HALF_W];
            RA_SNAP_REAL_LO: rd_data = real_snap[HALF_W-1:0];
            default:         rd_data = real_snap[CNT_W-1:HALF_W];
        endcase
    end
endmodule

// File: rtl/acq_timer_chk.sv
module acq_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             acq_enable,
    input logic             snap_req,
    input logic             wr_en,
    input logic             run_permit,
    input logic [CNT_W-1:0] live_cnt,
    input logic [CNT_W-1:0] real_cnt,
    input logic [CNT_W-1:0] live_snap,
    input logic [CNT_W-1:0] real_snap
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3: without a write, the real count moves down by at most one per cycle
    assert_real_step_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en)) |->
        (real_cnt == $past(real_cnt) || real_cnt == $past(real_cnt) - 1'b1));

    // R5: disabled acquisition freezes both counts
    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en) && !$past(acq_enable)) |->
        ($stable(live_cnt) && $stable(real_cnt)));

    // R5: no tick, no movement
    assert_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en) && !$past(tick)) |->
        ($stable(live_cnt) && $stable(real_cnt)));

    // R7: zero is sticky without a write
    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en) && $past(live_cnt) == '0) |-> (live_cnt == '0));

    // R8: the permit never stands while a count is zero
    assert_permit_R8: assert property (@(posedge clk) disable iff (rst)
        run_permit |-> (live_cnt != '0 && real_cnt != '0));

    // R9: snapshots hold unless requested
    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(snap_req)) |-> ($stable(live_snap) && $stable(real_snap)));

    // R9: a request captures both counts of the same cycle
    assert_snap_take_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(snap_req)) |->
        (live_snap == $past(live_cnt) && real_snap == $past(real_cnt)));
endmodule

bind acq_timer_top acq_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .acq_enable (acq_enable),
    .snap_req   (snap_req),
    .wr_en      (wr_en),
    .run_permit (run_permit),
    .live_cnt   (live_cnt),
    .real_cnt   (real_cnt),
    .live_snap  (live_snap),
    .real_snap  (real_snap)
);

// File: tb/acq_timer_top_tb.sv
module acq_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst, tick, busy, acq_enable, snap_req, wr_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        run_permit;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    acq_timer_top dut_i (.*);

    // live preset, real preset, tick count, busy on odd ticks
    localparam int NV = 5;
    localparam logic [72:0] VEC [NV] = '{
        {32'h0000_0010, 32'h0000_0020, 8'd5,  1'b0},
        {32'h0000_0010, 32'h0000_0020, 8'd7,  1'b1},
        {32'h0000_0003, 32'h0000_0100, 8'd9,  1'b0},
        {32'h0001_0001, 32'h0000_0004, 8'd6,  1'b0},
        {32'h0002_0000, 32'h0003_0002, 8'd10, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd32(input logic [2:0] lo, output logic [31:0] v);
        rd_addr = lo;      #0.5; v[15:0]  = rd_data;
        rd_addr = lo + 1;  #0.5; v[31:16] = rd_data;
    endtask

    task automatic preset(input logic [31:0] l, input logic [31:0] r);
        wr(3'd0, l[15:0]); wr(3'd1, l[31:16]);
        wr(3'd2, r[15:0]); wr(3'd3, r[31:16]);
    endtask

    task automatic ticks(input int n, input logic pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1; busy = pat && i[0];
        end
        @(negedge clk); tick = 0; busy = 0;
    endtask

    function automatic logic [31:0] sat(input logic [31:0] v, input int n);
        return (v > 32'(n)) ? v - 32'(n) : 32'd0;
    endfunction

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, l, r, el, er;
        int n;
        rst = 1; tick = 0; busy = 0; acq_enable = 0; snap_req = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        rd32(3'd0, v); chk("R1 live", v, 0);
        rd32(3'd2, v); chk("R1 real", v, 0);
        rd32(3'd4, v); chk("R1 snap live", v, 0);
        rd32(3'd6, v); chk("R1 snap real", v, 0);
        chk("R1 permit", {31'd0, run_permit}, 0);

        // R2: one half only
        wr(3'd0, 16'h1234);
        rd32(3'd0, v); chk("R2 live low only", v, 32'h0000_1234);
        wr(3'd3, 16'hABCD);
        rd32(3'd2, v); chk("R2 real high only", v, 32'hABCD_0000);

        // R3 R4 R7 R8: table walk
        for (int k = 0; k < NV; k++) begin
            l = VEC[k][72:41]; r = VEC[k][40:9]; n = int'(VEC[k][8:1]);
            preset(l, r);
            acq_enable = 1;
            ticks(n, VEC[k][0]);
            acq_enable = 0;
            er = sat(r, n);
            el = sat(l, VEC[k][0] ? (n + 1) / 2 : n);
            rd32(3'd2, v); chk("R3 real count", v, er);
            rd32(3'd0, v); chk("R4 live count", v, el);
            chk("R8 permit", {31'd0, run_permit}, {31'd0, (el != 0) && (er != 0)});
        end

        // R5: frozen while disabled
        preset(32'd50, 32'd60);
        ticks(4, 1'b0);
        rd32(3'd0, v); chk("R5 live frozen", v, 32'd50);
        rd32(3'd2, v); chk("R5 real frozen", v, 32'd60);

        // R6: write during a tick wins
        acq_enable = 1;
        @(negedge clk); tick = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 16'h0500;
        @(negedge clk); tick = 0; wr_en = 0;
        acq_enable = 0;
        rd32(3'd2, v); chk("R6 real written", v, 32'h0000_0500);
        rd32(3'd0, v); chk("R6 live stepped", v, 32'd49);

        // R7: saturation
        preset(32'd2, 32'd100);
        acq_enable = 1; ticks(5, 1'b0); acq_enable = 0;
        rd32(3'd0, v); chk("R7 live at zero", v, 0);
        chk("R7 permit low", {31'd0, run_permit}, 0);

        // R9: snapshot, hold, write ignored
        preset(32'h0001_2222, 32'h0003_4444);
        @(negedge clk); snap_req = 1;
        @(negedge clk); snap_req = 0;
        acq_enable = 1; ticks(3, 1'b0); acq_enable = 0;
        wr(3'd4, 16'hDEAD); wr(3'd7, 16'hBEEF);
        rd32(3'd4, v); chk("R9 snap live", v, 32'h0001_2222);
        rd32(3'd6, v); chk("R9 snap real", v, 32'h0003_4444);
        rd32(3'd0, v); chk("R9 running moved", v, 32'h0001_221F);

        // R10: all ones and borrow
        preset(32'hFFFF_FFFF, 32'h0001_0000);
        chk("R10 permit", {31'd0, run_permit}, 1);
        acq_enable = 1; ticks(1, 1'b0); acq_enable = 0;
        rd32(3'd0, v); chk("R10 all ones", v, 32'hFFFF_FFFE);
        rd32(3'd2, v); chk("R10 borrow", v, 32'h0000_FFFF);

        // R1: reset clears again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd32(3'd0, v); chk("R1 re-reset live", v, 0);
        rd32(3'd4, v); chk("R1 re-reset snap", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule